// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Write Controller

This block sits on the host side of a 16-bit parallel-input, current-output DAC that holds each code in two stages: a front (input) register and a back (output) register that sets the analog level. A client hands the controller one request: a code, an operation and a supply-range flag. The controller then drives the DAC's data bus, its active-low write strobe, its active-high load strobe and its active-low clear line. It counts clock cycles so that every setup, pulse-width and hold rule of the selected supply range is met.

Four operations are offered. Stage writes a code into the front register only. Update copies the front register to the back register, so several converters can be staged one at a time and then moved together. Pass-through asserts write and load together, so that the code goes through both registers in one pulse. Clear pulses the clear line, which zeroes both registers. Timing limits in nanoseconds are parameters. They are converted to whole cycles with a clock-period parameter and rounded up, with a floor of one cycle. One of two limit sets (high supply or low supply) is chosen per request.

Top module: `dacwr_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), and within one cycle of it even in the middle of an operation, busy is 0, dac_wr_n is 1, dac_ldac is 0, dac_clr_n is 1 and dac_data is 0.
- R2: A request is taken only at a clock edge where req_valid is 1 and busy is 0. busy is 1 from the next cycle until every strobe is back at its idle level (dac_wr_n 1, dac_ldac 0, dac_clr_n 1). Requests presented while busy is 1 have no effect on the bus, the strobes or the DAC registers.
- R3: req_mode encodes 0 = stage, 1 = update, 2 = pass-through, 3 = clear. Only stage and pass-through place req_code on dac_data; update and clear leave the bus at its previous value.
- R4: In stage and pass-through, dac_data carries the new code for at least SETUP cycles before dac_wr_n falls.
- R5: dac_wr_n stays low for at least PULSE cycles.
- R6: In update, dac_ldac stays high for at least PULSE cycles while dac_wr_n stays high.
- R7: In clear, dac_clr_n stays low for at least PULSE cycles, and dac_wr_n stays 1 and dac_ldac stays 0 throughout.
- R8: dac_data stays unchanged for at least one full cycle after dac_wr_n rises.
- R9: In pass-through, dac_wr_n is low and dac_ldac is high in exactly the same cycles, for PULSE cycles, after which both DAC registers hold the code.
- R10: cfg_low_supply, sampled when the request is taken, selects the limit set. SETUP and PULSE are ceil(limit_ns / CLK_PERIOD_NS), with a minimum of 1. With the defaults (20 ns clock; 20 ns high-supply limits; 35 ns low-supply limits) the high-supply set gives 1/1 cycles and the low-supply set gives 2/2.
- R11: Stage changes only the front register; the back register keeps its value until a later update copies the front register into it.
- R12: busy stays high for exactly SETUP+PULSE+1 cycles in stage and pass-through, and for exactly PULSE cycles in update and clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its period must equal CLK_PERIOD_NS |
| rst_n | input | 1 | Synchronous active-low reset of the controller |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 2 | Operation: 0 stage, 1 update, 2 pass-through, 3 clear |
| req_code | input | CODE_W | Code to write (bit 15 MSB); used by stage and pass-through |
| cfg_low_supply | input | 1 | 1 selects the low-supply limit set for this request |
| busy | output | 1 | Operation in progress; new requests are refused |
| dac_data | output | CODE_W | Parallel data bus to the DAC |
| dac_wr_n | output | 1 | Write strobe to the DAC, active low |
| dac_ldac | output | 1 | Load strobe to the DAC, active high |
| dac_clr_n | output | 1 | Clear line to the DAC, active low |

## Verification
The pulse-width and setup properties assume that the clock really runs at CLK_PERIOD_NS. They also assume that the limit set latched at acceptance stays put until the operation ends, which holds only because nothing is accepted while busy. The bus-change property assumes that requests are sampled only on rising edges. The stimulus changes every request input at the falling edge and keeps each request for exactly one accepting edge. The exception is the deliberate refusal case, where a request is held across busy cycles to show that it is ignored. The clock matches the period parameter, so the cycle counts the checker derives match the nanosecond limits.

// File: rtl/dacwr_pkg.sv
// Shared types and helpers for the DAC write controller.
// Assumes timing limits are given in whole nanoseconds.
package dacwr_pkg;

    typedef enum logic [1:0] {
        OP_STAGE  = 2'd0,
        OP_UPDATE = 2'd1,
        OP_TRANSP = 2'd2,
        OP_CLEAR  = 2'd3
    } dac_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } seq_state_e;

    // Round a nanosecond limit up to whole cycles, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ns);
        int unsigned c;
        c = (ns + period_ns - 1) / period_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Operations that move a code over the bus with the write strobe.
    function automatic logic op_writes(input dac_op_e op);
        return (op == OP_STAGE) || (op == OP_TRANSP);
    endfunction

    // Operations that raise the load strobe.
    function automatic logic op_loads(input dac_op_e op);
        return (op == OP_UPDATE) || (op == OP_TRANSP);
    endfunction

endpackage

// File: rtl/dacwr_limits.sv
// Selects the setup and pulse cycle counts for the latched supply range.
// Assumes sel_low is held stable for the whole operation.
module dacwr_limits #(
    parameter int unsigned CNT_W        = 2,
    parameter int unsigned HI_SETUP_CYC = 1,
    parameter int unsigned HI_PULSE_CYC = 1,
    parameter int unsigned LO_SETUP_CYC = 2,
    parameter int unsigned LO_PULSE_CYC = 2
) (
    input  logic             sel_low,
    output logic [CNT_W-1:0] setup_cyc,
    output logic [CNT_W-1:0] pulse_cyc
);

    // Pick the active limit set.
    always_comb begin
        setup_cyc = sel_low ? CNT_W'(LO_SETUP_CYC) : CNT_W'(HI_SETUP_CYC);
        pulse_cyc = sel_low ? CNT_W'(LO_PULSE_CYC) : CNT_W'(HI_PULSE_CYC);
    end

endmodule

// File: rtl/dacwr_seq.sv
// Operation sequencer: takes one request while idle, then walks the
// setup, strobe and hold phases, timing each with a cycle counter.
// Exposes next-state values so the pin stage can register its outputs
// in step with the state register. Assumes setup_cyc/pulse_cyc >= 1.
module dacwr_seq
    import dacwr_pkg::*;
#(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  dac_op_e          req_op,
    input  logic             cfg_low_supply,
    input  logic [CNT_W-1:0] setup_cyc,
    input  logic [CNT_W-1:0] pulse_cyc,
    output logic             accept,
    output seq_state_e       state_q,
    output seq_state_e       state_d,
    output dac_op_e          op_d,
    output logic             sel_low_q
);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    dac_op_e          op_q;
    logic             sel_low_d;

    // Next-state, phase counter and request capture decisions.
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q + CNT_W'(1);
        op_d      = op_q;
        sel_low_d = sel_low_q;
        accept    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (req_valid) begin
                    accept    = 1'b1;
                    op_d      = req_op;
                    sel_low_d = cfg_low_supply;
                    state_d   = op_writes(req_op) ? ST_SETUP : ST_STROBE;
                end
            end
            ST_SETUP: begin
                if (cnt_q + CNT_W'(1) == setup_cyc) begin
                    state_d = ST_STROBE;
                    cnt_d   = '0;
                end
            end
            ST_STROBE: begin
                if (cnt_q + CNT_W'(1) == pulse_cyc) begin
                    state_d = op_writes(op_q) ? ST_HOLD : ST_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State, counter and latched request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            op_q      <= OP_STAGE;
            sel_low_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            op_q      <= op_d;
            sel_low_q <= sel_low_d;
        end
    end

endmodule

// File: rtl/dacwr_drive.sv
// Pin stage: registers the data bus and the three DAC control lines
// from the sequencer's next state, so no pin is driven by a decode.
// Assumes op_d equals the new operation in the accepting cycle.
module dacwr_drive
    import dacwr_pkg::*;
#(
    parameter int unsigned CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [CODE_W-1:0] req_code,
    input  seq_state_e        state_d,
    input  dac_op_e           op_d,
    output logic [CODE_W-1:0] dac_data,
    output logic              dac_wr_n,
    output logic              dac_ldac,
    output logic              dac_clr_n
);

    logic strobe_phase;

    // The strobes are active only in the strobe phase.
    always_comb strobe_phase = (state_d == ST_STROBE);

    // Bus register: takes a new code only when a write operation is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_data <= '0;
        end else if (accept && op_writes(op_d)) begin
            dac_data <= req_code;
        end
    end

    // Control-line registers, decoded per operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_wr_n  <= 1'b1;
            dac_ldac  <= 1'b0;
            dac_clr_n <= 1'b1;
        end else begin
            dac_wr_n  <= !(strobe_phase && op_writes(op_d));
            dac_ldac  <= strobe_phase && op_loads(op_d);
            dac_clr_n <= !(strobe_phase && (op_d == OP_CLEAR));
        end
    end

endmodule

// File: rtl/dacwr_ctrl.sv
// Top of the double-buffered DAC write controller. Converts nanosecond
// limits into cycle counts and joins the sequencer, the limit selector
// and the pin stage. Assumes clk runs at CLK_PERIOD_NS.
module dacwr_ctrl
    import dacwr_pkg::*;
#(
    parameter int unsigned CODE_W        = 16,
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned HI_SETUP_NS   = 20,
    parameter int unsigned HI_PULSE_NS   = 20,
    parameter int unsigned LO_SETUP_NS   = 35,
    parameter int unsigned LO_PULSE_NS   = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_mode,
    input  logic [CODE_W-1:0] req_code,
    input  logic              cfg_low_supply,
    output logic              busy,
    output logic [CODE_W-1:0] dac_data,
    output logic              dac_wr_n,
    output logic              dac_ldac,
    output logic              dac_clr_n
);

    localparam int unsigned HI_SETUP_CYC = ns_to_cyc(HI_SETUP_NS, CLK_PERIOD_NS);
    localparam int unsigned HI_PULSE_CYC = ns_to_cyc(HI_PULSE_NS, CLK_PERIOD_NS);
    localparam int unsigned LO_SETUP_CYC = ns_to_cyc(LO_SETUP_NS, CLK_PERIOD_NS);
    localparam int unsigned LO_PULSE_CYC = ns_to_cyc(LO_PULSE_NS, CLK_PERIOD_NS);
    localparam int unsigned MAX_CYC      = max2(max2(HI_SETUP_CYC, HI_PULSE_CYC),
                                                max2(LO_SETUP_CYC, LO_PULSE_CYC));
    localparam int unsigned CNT_W        = $clog2(MAX_CYC + 1);

    logic             accept;
    seq_state_e       state_q, state_d;
    dac_op_e          op_d;
    logic             sel_low_q;
    logic [CNT_W-1:0] setup_cyc, pulse_cyc;

    dacwr_limits #(
        .CNT_W        (CNT_W),
        .HI_SETUP_CYC (HI_SETUP_CYC),
        .HI_PULSE_CYC (HI_PULSE_CYC),
        .LO_SETUP_CYC (LO_SETUP_CYC),
        .LO_PULSE_CYC (LO_PULSE_CYC)
    ) limits_i (
        .sel_low   (sel_low_q),
        .setup_cyc (setup_cyc),
        .pulse_cyc (pulse_cyc)
    );

    dacwr_seq #(.CNT_W(CNT_W)) seq_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_op         (dac_op_e'(req_mode)),
        .cfg_low_supply (cfg_low_supply),
        .setup_cyc      (setup_cyc),
        .pulse_cyc      (pulse_cyc),
        .accept         (accept),
        .state_q        (state_q),
        .state_d        (state_d),
        .op_d           (op_d),
        .sel_low_q      (sel_low_q)
    );

    dacwr_drive #(.CODE_W(CODE_W)) drive_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_code  (req_code),
        .state_d   (state_d),
        .op_d      (op_d),
        .dac_data  (dac_data),
        .dac_wr_n  (dac_wr_n),
        .dac_ldac  (dac_ldac),
        .dac_clr_n (dac_clr_n)
    );

    // Busy covers every non-idle phase, including the data hold cycle.
    always_comb busy = (state_q != ST_IDLE);

endmodule

// File: rtl/dacwr_ctrl_chk.sv
// Protocol checker for dacwr_ctrl: measures pulse widths and data age
// with its own counters and compares them with the active limit set.
module dacwr_ctrl_chk #(
    parameter int unsigned CODE_W = 16,
    parameter int unsigned CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [CODE_W-1:0] dac_data,
    input logic              dac_wr_n,
    input logic              dac_ldac,
    input logic              dac_clr_n,
    input logic [CNT_W-1:0]  setup_cyc,
    input logic [CNT_W-1:0]  pulse_cyc
);

    localparam int unsigned RUN_W = CNT_W + 1;

    logic [RUN_W-1:0]  wr_run, ld_run, clr_run, data_age;
    logic [CODE_W-1:0] data_prev;
    logic              busy_prev;

    // Run-length and age counters, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_run    <= '0;
            ld_run    <= '0;
            clr_run   <= '0;
            data_age  <= '0;
            data_prev <= '0;
            busy_prev <= 1'b0;
        end else begin
            wr_run    <= !dac_wr_n  ? ((wr_run  == '1) ? wr_run  : wr_run  + RUN_W'(1)) : '0;
            ld_run    <=  dac_ldac  ? ((ld_run  == '1) ? ld_run  : ld_run  + RUN_W'(1)) : '0;
            clr_run   <= !dac_clr_n ? ((clr_run == '1) ? clr_run : clr_run + RUN_W'(1)) : '0;
            data_age  <= (dac_data != data_prev) ? RUN_W'(1)
                       : ((data_age == '1) ? data_age : data_age + RUN_W'(1));
            data_prev <= dac_data;
            busy_prev <= busy;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dac_wr_n && !dac_ldac && dac_clr_n)); // R2
    AST_BUS_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_data != data_prev) |-> !busy_prev); // R2
    AST_SETUP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_wr_n) |-> (data_age >= {1'b0, setup_cyc})); // R4
    AST_WR_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_wr_n && wr_run != '0) |-> (wr_run >= {1'b0, pulse_cyc})); // R5
    AST_LOAD_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_ldac && ld_run != '0) |-> (ld_run >= {1'b0, pulse_cyc})); // R6
    AST_CLEAR_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_clr_n && clr_run != '0) |-> (clr_run >= {1'b0, pulse_cyc})); // R7
    AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_clr_n |-> (dac_wr_n && !dac_ldac)); // R7
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_wr_n) |=> $stable(dac_data)); // R8

endmodule

bind dacwr_ctrl dacwr_ctrl_chk #(
    .CODE_W (CODE_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .dac_data  (dac_data),
    .dac_wr_n  (dac_wr_n),
    .dac_ldac  (dac_ldac),
    .dac_clr_n (dac_clr_n),
    .setup_cyc (setup_cyc),
    .pulse_cyc (pulse_cyc)
);

// File: tb/dacwr_ctrl_tb_top.sv
// Behavioural model of the converter's two registers: clear zeroes both,
// a low write strobe makes the front register follow the bus, and a high
// load strobe copies the front register (or the bus while writing) to the back.
module dac_pair_model #(
    parameter int unsigned W = 16
) (
    input  logic         clr_n,
    input  logic         wr_n,
    input  logic         ldac,
    input  logic [W-1:0] d,
    output logic [W-1:0] in_q,
    output logic [W-1:0] out_q
);
    always_latch begin
        if (!clr_n) begin
            in_q  = '0;
            out_q = '0;
        end else begin
            if (!wr_n) in_q = d;
            if (ldac)  out_q = wr_n ? in_q : d;
        end
    end
endmodule

module dacwr_ctrl_tb_top;

    localparam int CLK_NS = 20;
    localparam int HS = (20 + CLK_NS - 1) / CLK_NS;   // high-supply setup and pulse
    localparam int LS = (35 + CLK_NS - 1) / CLK_NS;   // low-supply setup and pulse

    typedef struct packed {
        logic [1:0]  mode;
        logic        low;
        logic [15:0] code;
        logic [15:0] exp_in;
        logic [15:0] exp_out;
        logic [3:0]  exp_busy;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{2'd3, 1'b0, 16'hDEAD, 16'h0000, 16'h0000, 4'd1},
        '{2'd0, 1'b0, 16'h1234, 16'h1234, 16'h0000, 4'd3},
        '{2'd1, 1'b0, 16'hBEEF, 16'h1234, 16'h1234, 4'd1},
        '{2'd2, 1'b1, 16'h8000, 16'h8000, 16'h8000, 4'd5},
        '{2'd0, 1'b1, 16'hFFFF, 16'hFFFF, 16'h8000, 4'd5},
        '{2'd1, 1'b1, 16'h0F0F, 16'hFFFF, 16'hFFFF, 4'd2},
        '{2'd3, 1'b1, 16'h1111, 16'h0000, 16'h0000, 4'd2},
        '{2'd2, 1'b0, 16'hA5A5, 16'hA5A5, 16'hA5A5, 4'd3},
        '{2'd0, 1'b0, 16'h0001, 16'h0001, 16'hA5A5, 4'd3},
        '{2'd1, 1'b0, 16'h7777, 16'h0001, 16'h0001, 4'd1},
        '{2'd3, 1'b0, 16'h2222, 16'h0000, 16'h0000, 4'd1},
        '{2'd2, 1'b0, 16'h7FFF, 16'h7FFF, 16'h7FFF, 4'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_mode = 2'd0;
    logic [15:0] req_code = '0;
    logic        cfg_low_supply = 1'b0;
    logic        busy;
    logic [15:0] dac_data;
    logic        dac_wr_n, dac_ldac, dac_clr_n;
    logic [15:0] in_q, out_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    dacwr_ctrl dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_mode       (req_mode),
        .req_code       (req_code),
        .cfg_low_supply (cfg_low_supply),
        .busy           (busy),
        .dac_data       (dac_data),
        .dac_wr_n       (dac_wr_n),
        .dac_ldac       (dac_ldac),
        .dac_clr_n      (dac_clr_n)
    );

    dac_pair_model #(.W(16)) model_i (
        .clr_n (dac_clr_n),
        .wr_n  (dac_wr_n),
        .ldac  (dac_ldac),
        .d     (dac_data),
        .in_q  (in_q),
        .out_q (out_q)
    );

    // Pin monitor, sampled at the falling edge.
    int m_setup, m_wr, m_ld, m_clr, m_busy, m_both, m_single, m_conflict;
    bit m_hold_ok, hold_armed;
    int age, wr_run, ld_run, clr_run, busy_run;
    logic [15:0] prev_data = '0;
    logic prev_wr = 1'b1, prev_ld = 1'b0, prev_clr = 1'b1, prev_busy = 1'b0;

    always @(negedge clk) begin
        if (dac_data !== prev_data) age = 1; else age = age + 1;
        if (hold_armed) begin m_hold_ok = (dac_data === prev_data); hold_armed = 1'b0; end
        if (prev_wr && !dac_wr_n) m_setup = age - 1;
        if (!dac_wr_n) wr_run = wr_run + 1;
        else if (!prev_wr) begin m_wr = wr_run; wr_run = 0; hold_armed = 1'b1; end
        if (dac_ldac) ld_run = ld_run + 1;
        else if (prev_ld) begin m_ld = ld_run; ld_run = 0; end
        if (!dac_clr_n) begin
            clr_run = clr_run + 1;
            if (!dac_wr_n || dac_ldac) m_conflict = m_conflict + 1;
        end else if (!prev_clr) begin m_clr = clr_run; clr_run = 0; end
        if (busy) busy_run = busy_run + 1;
        else if (prev_busy) begin m_busy = busy_run; busy_run = 0; end
        if (!dac_wr_n && dac_ldac) m_both = m_both + 1;
        if (!dac_wr_n != dac_ldac) m_single = m_single + 1;
        prev_data = dac_data; prev_wr = dac_wr_n; prev_ld = dac_ldac;
        prev_clr = dac_clr_n; prev_busy = busy;
    end

    task automatic chk(input string tag, input int act, input int exp, input bit at_least = 1'b0);
        bit ok;
        ok = at_least ? (act >= exp) : (act == exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %s%0h", tag, act, at_least ? ">=" : "", exp);
        end
    endtask

    task automatic clear_meas();
        m_setup = 0; m_wr = 0; m_ld = 0; m_clr = 0; m_busy = 0;
        m_both = 0; m_single = 0; m_conflict = 0; m_hold_ok = 1'b0;
    endtask

    // Issue one request at a falling edge, then wait until the operation is done.
    task automatic run_op(input logic [1:0] mode, input logic low, input logic [15:0] code);
        clear_meas();
        req_mode = mode; cfg_low_supply = low; req_code = code; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic check_idle_pins(input string tag);
        chk({tag, " busy"}, busy, 0);
        chk({tag, " wr_n"}, dac_wr_n, 1);
        chk({tag, " ldac"}, dac_ldac, 0);
        chk({tag, " clr_n"}, dac_clr_n, 1);
        chk({tag, " data"}, dac_data, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] last_bus;
        int p;
        age = 0; wr_run = 0; ld_run = 0; clr_run = 0; busy_run = 0; hold_armed = 1'b0;
        clear_meas();
        repeat (4) @(negedge clk);
        #1;
        check_idle_pins("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk); #1;
        last_bus = 16'h0000;

        // Table walk.
        for (int i = 0; i < NVEC; i++) begin
            run_op(VECS[i].mode, VECS[i].low, VECS[i].code);
            p = VECS[i].low ? LS : HS;
            if (VECS[i].mode == 2'd0 || VECS[i].mode == 2'd2) last_bus = VECS[i].code;
            chk("R3 output register", out_q, VECS[i].exp_out);
            chk("R3 input register", in_q, VECS[i].exp_in);
            chk("R3 data bus", dac_data, last_bus);
            chk("R12 busy length", m_busy, VECS[i].exp_busy);
            case (VECS[i].mode)
                2'd0, 2'd2: begin
                    chk("R4 setup cycles", m_setup, p, 1'b1);
                    chk("R10 setup for supply", m_setup, p);
                    chk("R5 write pulse", m_wr, p, 1'b1);
                    chk("R10 write pulse for supply", m_wr, p);
                    chk("R8 data hold after write", m_hold_ok, 1);
                    if (VECS[i].mode == 2'd0) chk("R11 no load in stage", m_ld, 0);
                    else begin
                        chk("R9 overlap cycles", m_both, p);
                        chk("R9 unpaired strobe cycles", m_single, 0);
                    end
                end
                2'd1: begin
                    chk("R6 load pulse", m_ld, p, 1'b1);
                    chk("R6 no write in update", m_wr, 0);
                end
                default: begin
                    chk("R7 clear pulse", m_clr, p, 1'b1);
                    chk("R7 strobes idle during clear", m_conflict, 0);
                end
            endcase
        end

        // R2: a request held while busy is refused.
        clear_meas();
        req_mode = 2'd0; cfg_low_supply = 1'b1; req_code = 16'h5555; req_valid = 1'b1;
        @(negedge clk);
        req_mode = 2'd2; req_code = 16'h3333;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk); #1;
        chk("R2 bus after refused request", dac_data, 16'h5555);
        chk("R2 input register after refused request", in_q, 16'h5555);
        chk("R2 output register after refused request", out_q, 16'h7FFF);
        chk("R2 busy length with refused request", m_busy, 5);
        chk("R2 pins idle after operation", {dac_wr_n, dac_ldac, dac_clr_n}, 3'b101);

        // R11: update after stage moves the staged code.
        run_op(2'd1, 1'b0, 16'h0000);
        chk("R11 output after update", out_q, 16'h5555);

        // R1: synchronous reset in the middle of a pass-through.
        req_mode = 2'd2; cfg_low_supply = 1'b1; req_code = 16'h2468; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk); #1;
        check_idle_pins("R1 reset mid operation");
        rst_n = 1'b1;
        @(negedge clk); #1;
        check_idle_pins("R1 after reset release");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule